// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the digital control core of a small four-wire serial EEPROM, written to run inside a synchronous system clock domain. An external host selects it with a chip-select line and clocks in a command bit by bit on a serial data line. The command holds a start marker, a two-bit opcode, an address, and for programming commands a data word. The block decodes the command and then does one of three things. It returns stored data on a serial output, it updates an internal register array, or it changes its programming-enable latch.

Programming commands are self-timed. While the timer runs, a ready line is held low. A configuration input selects the word size: 16-bit words addressed by `ADDR_W` bits, or 8-bit bytes addressed by `ADDR_W+1` bits. Both views share one byte array. The serial output has a separate drive-enable so that a pad can tri-state it. The serial clock, data and select lines are synchronised into the system clock. Serial clock edges are detected after synchronisation.

Top module: `serial_eeprom_slave`

## Requirements
- R1: While chip select is high and no command is in progress, sampled zeros on the data input are ignored. The first '1' sampled on a rising serial clock edge is the start bit. The next bits are the opcode, MSB first, followed by the address, MSB first.
- R2: Opcode 10 reads. After the last address bit, the output is enabled and drives a single '0'. Each following rising serial clock edge then presents the next data bit, MSB first. The rising edge after the last data bit releases the output enable.
- R3: With `org_wide_i`=1, words are 16 bits and the address has `ADDR_W` bits. With `org_wide_i`=0, words are 8 bits and the address has `ADDR_W+1` bits. Word n in 16-bit mode is byte 2n+1 (high half) together with byte 2n (low half).
- R4: Reset clears the programming-enable latch. While the latch is clear, write, erase-all and write-all commands change no memory and do not drop ready.
- R5: Opcode 00 takes its sub-command from the two top address bits: 11 sets the latch, 00 clears it, 10 is erase-all and 01 is write-all. The remaining address bits are don't-care.
- R6: A read returns the stored word whatever the state of the programming-enable latch.
- R7: A second opcode bit of 1 (opcode 01 or 11) is a single-word write. Ready stays low for exactly `WAIT_CYC` system clock cycles. For write and write-all this period starts after the last data bit. For erase-all it starts after the last address bit.
- R8: Erase-all sets every bit of the array to 1.
- R9: Write-all stores the supplied word into every location.
- R10: While ready is low, all serial activity is ignored, including commands that would change the latch. The output is not driven during this time.
- R11: The output enable is low whenever chip select is low and whenever no read data is being shifted. Dropping chip select before a command completes aborts it and leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_i | input | 1 | Chip select from the host, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Serial data in, sampled on rising serial clock |
| org_wide_i | input | 1 | 1 = 16-bit words, 0 = 8-bit words (held static; a pad pull-up gives 1 when open) |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Drive enable for the serial data out pad |
| ready_o | output | 1 | 1 = ready, 0 = self-timed programming in progress |

## Verification
The assertions rely on the serial clock running slowly compared with the system clock. Each high and low phase lasts several system cycles, so the synchroniser sees every edge. They also rely on the data input being stable before each rising serial clock, and on the word-size input staying fixed within a command. The bench drives every serial line on the falling system clock edge. It holds each serial clock phase for four system cycles and changes data only while the serial clock is low. It changes the word-size selection only between commands, including in the random phase, where opcodes, addresses, data and word size are drawn from a seeded generator.

// File: rtl/sesc_pkg.sv
package sesc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DIN,
        ST_ROUT,
        ST_BUSY,
        ST_DONE
    } sesc_state_e;

    typedef enum logic {
        WK_SINGLE,
        WK_ALL
    } sesc_wkind_e;

endpackage

// File: rtl/sesc_insync.sv
module sesc_insync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= raw_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign sync_o = s2_q;
    assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/sesc_array.sv
module sesc_array #(
    parameter int AB = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_i,
    input  logic          wr_en_i,
    input  logic          wr_all_i,
    input  logic [AB-1:0] wr_addr_i,
    input  logic [15:0]   wr_data_i,
    input  logic [AB-1:0] rd_addr_i,
    output logic [15:0]   rd_data_o
);
    localparam int NB = 1 << AB;

    logic [NB*8-1:0] flat;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic       hit;
        logic [7:0] val;
        logic [7:0] byte_q;

        always_comb begin
            if (wide_i) begin
                hit = wr_all_i || (wr_addr_i[AB-2:0] == (AB-1)'(i / 2));
                val = (i % 2 == 1) ? wr_data_i[15:8] : wr_data_i[7:0];
            end else begin
                hit = wr_all_i || (wr_addr_i == AB'(i));
                val = wr_data_i[7:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en_i && hit) begin
                byte_q <= val;
            end
        end

        assign flat[i*8 +: 8] = byte_q;
    end

    always_comb begin
        if (wide_i) begin
            rd_data_o = {flat[{rd_addr_i[AB-2:0], 1'b1}*8 +: 8],
                         flat[{rd_addr_i[AB-2:0], 1'b0}*8 +: 8]};
        end else begin
            rd_data_o = {flat[rd_addr_i*8 +: 8], 8'h00};
        end
    end
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import sesc_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int WAIT_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic org_wide_i,
    output logic sdo_o,
    output logic sdo_oe_o,
    output logic ready_o
);
    localparam int AB = ADDR_W + 1;
    localparam int HW = AB + 2;
    localparam int CW = $clog2(HW + 18);
    localparam int TW = $clog2(WAIT_CYC + 1);

    typedef struct packed {
        sesc_state_e state;
        sesc_wkind_e kind;
        logic [CW-1:0] cnt;
        logic [HW-1:0] hdr;
        logic [15:0]   din;
        logic [15:0]   osr;
        logic          dout;
        logic          oe;
        logic          wen;
        logic [TW-1:0] timer;
        logic          mwe;
        logic          mall;
        logic [AB-1:0] maddr;
        logic [15:0]   mdata;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [2:0] sync_v, rise_v;
    logic       cs_s, sdi_s, rise_sclk, wide;
    logic [HW-1:0] hdr_n;
    logic [15:0]   din_n, rd_word;
    logic [1:0]    dec_op, dec_sub;
    logic [AB-1:0] dec_addr;
    logic [CW-1:0] hdr_len, data_len;

    sesc_insync #(.W(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({cs_i, sclk_i, sdi_i}),
        .sync_o (sync_v),
        .rise_o (rise_v)
    );

    assign cs_s      = sync_v[2];
    assign rise_sclk = rise_v[1];
    assign sdi_s     = sync_v[0];
    assign wide      = org_wide_i;

    assign hdr_n    = {r_q.hdr[HW-2:0], sdi_s};
    assign din_n    = {r_q.din[14:0], sdi_s};
    assign dec_op   = wide ? hdr_n[ADDR_W+1:ADDR_W] : hdr_n[AB+1:AB];
    assign dec_addr = wide ? {1'b0, hdr_n[ADDR_W-1:0]} : hdr_n[AB-1:0];
    assign dec_sub  = wide ? hdr_n[ADDR_W-1:ADDR_W-2] : hdr_n[AB-1:AB-2];
    assign hdr_len  = wide ? CW'(ADDR_W + 2) : CW'(AB + 2);
    assign data_len = wide ? CW'(16) : CW'(8);

    sesc_array #(.AB(AB)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_i    (wide),
        .wr_en_i   (r_q.mwe),
        .wr_all_i  (r_q.mall),
        .wr_addr_i (r_q.maddr),
        .wr_data_i (r_q.mdata),
        .rd_addr_i (dec_addr),
        .rd_data_o (rd_word)
    );

    always_comb begin
        r_d      = r_q;
        r_d.mwe  = 1'b0;
        r_d.mall = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                r_d.oe = 1'b0;
                if (cs_s && rise_sclk && sdi_s) begin
                    r_d.state = ST_CMD;
                    r_d.cnt   = '0;
                    r_d.hdr   = '0;
                end
            end
            ST_CMD: begin
                if (rise_sclk) begin
                    r_d.hdr   = hdr_n;
                    r_d.cnt   = r_q.cnt + 1'b1;
                    r_d.maddr = dec_addr;
                    if (r_q.cnt == hdr_len - 1'b1) begin
                        r_d.cnt = '0;
                        if (dec_op == 2'b10) begin
                            r_d.state = ST_ROUT;
                            r_d.osr   = rd_word;
                            r_d.dout  = 1'b0;
                            r_d.oe    = 1'b1;
                        end else if (dec_op[0]) begin
                            r_d.kind  = WK_SINGLE;
                            r_d.state = r_q.wen ? ST_DIN : ST_DONE;
                        end else begin
                            case (dec_sub)
                                2'b11: begin
                                    r_d.wen   = 1'b1;
                                    r_d.state = ST_DONE;
                                end
                                2'b00: begin
                                    r_d.wen   = 1'b0;
                                    r_d.state = ST_DONE;
                                end
                                2'b10: begin
                                    if (r_q.wen) begin
                                        r_d.mwe   = 1'b1;
                                        r_d.mall  = 1'b1;
                                        r_d.mdata = 16'hFFFF;
                                        r_d.state = ST_BUSY;
                                        r_d.timer = TW'(WAIT_CYC - 1);
                                    end else begin
                                        r_d.state = ST_DONE;
                                    end
                                end
                                default: begin
                                    r_d.kind  = WK_ALL;
                                    r_d.state = r_q.wen ? ST_DIN : ST_DONE;
                                end
                            endcase
                        end
                    end
                end
            end
            ST_DIN: begin
                if (rise_sclk) begin
                    r_d.din = din_n;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == data_len - 1'b1) begin
                        r_d.mwe   = 1'b1;
                        r_d.mall  = (r_q.kind == WK_ALL);
                        r_d.mdata = wide ? din_n : {8'h00, din_n[7:0]};
                        r_d.state = ST_BUSY;
                        r_d.timer = TW'(WAIT_CYC - 1);
                    end
                end
            end
            ST_ROUT: begin
                if (rise_sclk) begin
                    if (r_q.cnt == data_len) begin
                        r_d.oe    = 1'b0;
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.dout = r_q.osr[15];
                        r_d.osr  = {r_q.osr[14:0], 1'b0};
                        r_d.cnt  = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (r_q.timer == '0) begin
                    r_d.state = ST_DONE;
                end else begin
                    r_d.timer = r_q.timer - 1'b1;
                end
            end
            ST_DONE: begin
                r_d.oe = 1'b0;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
        if (!cs_s && r_q.state != ST_BUSY) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
            r_d.mwe   = 1'b0;
            r_d.mall  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo_o    = r_q.dout;
    assign sdo_oe_o = r_q.oe;
    assign ready_o  = (r_q.state != ST_BUSY);

    logic [TW:0] busy_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len_q <= '0;
        end else if (!ready_o) begin
            busy_len_q <= busy_len_q + 1'b1;
        end else begin
            busy_len_q <= '0;
        end
    end

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> busy_len_q == (TW+1)'(WAIT_CYC)); // R7
    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> !sdo_o); // R2
    AST_DO_OFF_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !sdo_oe_o); // R11
    AST_PROG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> r_q.wen); // R4
    AST_BUSY_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && $past(!ready_o)) |-> $stable(r_q.wen)); // R10
    AST_NO_DRIVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o |-> ready_o); // R10
endmodule

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb;
    localparam int CLK_P    = 10;
    localparam int AW16     = 6;
    localparam int BUSY_CYC = 300;
    localparam int HALF     = 4;
    localparam int NB       = 1 << (AW16 + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b1;
    logic sdo, sdo_oe, ready;

    int checks = 0, fails = 0;
    int busy_events = 0, last_len = 0, run = 0;
    logic [7:0] mdl [NB];
    logic mdl_en = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    serial_eeprom_slave #(.ADDR_W(AW16), .WAIT_CYC(BUSY_CYC)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_i       (cs),
        .sclk_i     (sclk),
        .sdi_i      (sdi),
        .org_wide_i (org),
        .sdo_o      (sdo),
        .sdo_oe_o   (sdo_oe),
        .ready_o    (ready)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            run = 0;
        end else if (!ready) begin
            run++;
        end else if (run != 0) begin
            busy_events++;
            last_len = run;
            run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic wide, input int a);
        int w;
        if (wide) begin
            w = a % (1 << AW16);
            return {mdl[2*w+1], mdl[2*w]};
        end
        return {8'h00, mdl[a % NB]};
    endfunction

    task automatic mdl_write(input logic wide, input int a, input logic [15:0] d);
        int w;
        if (wide) begin
            w = a % (1 << AW16);
            mdl[2*w+1] = d[15:8];
            mdl[2*w]   = d[7:0];
        end else begin
            mdl[a % NB] = d[7:0];
        end
    endtask

    task automatic tick(input logic b);
        @(negedge clk);
        sdi = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic sel_on();
        @(negedge clk);
        cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic sel_off();
        @(negedge clk);
        cs = 1'b0;
        sdi = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic send_head(input logic wide, input logic [1:0] op, input logic [6:0] a);
        int aw = wide ? AW16 : AW16 + 1;
        tick(1'b0);
        tick(1'b0);
        tick(1'b1);
        tick(op[1]);
        tick(op[0]);
        for (int i = aw - 1; i >= 0; i--) tick(a[i]);
    endtask

    task automatic do_read(input logic wide, input logic [6:0] a, input string req);
        logic [15:0] got = '0;
        logic [15:0] exp = exp_word(wide, a);
        int dw = wide ? 16 : 8;
        org = wide;
        sel_on();
        send_head(wide, 2'b10, a);
        repeat (HALF) @(negedge clk);
        chk(sdo_oe && !sdo, "R2", "dummy zero", {sdo_oe, sdo}, 2'b10);
        for (int i = 0; i < dw; i++) begin
            tick(1'b0);
            repeat (HALF) @(negedge clk);
            got = {got[14:0], sdo};
        end
        chk(got == exp, req, "read word", got, exp);
        tick(1'b0);
        repeat (HALF) @(negedge clk);
        chk(!sdo_oe, "R11", "release after data", sdo_oe, 0);
        sel_off();
    endtask

    task automatic do_write(input logic wide, input logic op1, input logic [6:0] a,
                            input logic [15:0] d, input bit wait_done, input string req);
        int ev0 = busy_events;
        int dw = wide ? 16 : 8;
        org = wide;
        sel_on();
        send_head(wide, {op1, 1'b1}, a);
        chk(!sdo_oe, "R11", "no drive during write", sdo_oe, 0);
        for (int i = dw - 1; i >= 0; i--) tick(d[i]);
        sel_off();
        if (mdl_en) mdl_write(wide, a, d);
        if (wait_done) begin
            wait_idle();
            repeat (2) @(negedge clk);
            if (mdl_en)
                chk(busy_events == ev0 + 1 && last_len == BUSY_CYC, req, "busy length",
                    last_len, BUSY_CYC);
            else
                chk(busy_events == ev0, "R4", "disabled write busy", busy_events - ev0, 0);
        end
    endtask

    task automatic do_ext(input logic wide, input logic [1:0] sub, input logic [15:0] d,
                          input bit wait_done);
        logic [6:0] a;
        int dw = wide ? 16 : 8;
        org = wide;
        a = wide ? {1'b0, sub, 4'($urandom)} : {sub, 5'($urandom)};
        sel_on();
        send_head(wide, 2'b00, a);
        if (sub == 2'b01) for (int i = dw - 1; i >= 0; i--) tick(d[i]);
        sel_off();
        if (wait_done) begin
            wait_idle();
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int ev0;
        int seed_val;
        seed_val = $urandom(32'd4711);
        for (int i = 0; i < NB; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R4", "ready after reset", ready, 1);
        chk(sdo_oe == 1'b0, "R11", "DO off after reset", sdo_oe, 0);

        // R4: latch clear after reset, write ignored; R6 read still works
        do_write(1'b1, 1'b0, 7'd5, 16'h1234, 1'b1, "R4");
        do_read(1'b1, 7'd5, "R6");

        // R5 set latch, R7 write, R1 leading zeros, R3 both sizes
        do_ext(1'b1, 2'b11, 16'h0, 1'b0);
        mdl_en = 1'b1;
        do_write(1'b1, 1'b0, 7'd5, 16'hA5C3, 1'b1, "R7");
        do_read(1'b1, 7'd5, "R1");
        do_write(1'b0, 1'b1, 7'd11, 16'h007E, 1'b1, "R7");
        do_read(1'b0, 7'd11, "R3");
        do_read(1'b1, 7'd5, "R3");
        do_read(1'b0, 7'd10, "R3");

        // R11: abort mid-data
        ev0 = busy_events;
        org = 1'b1;
        sel_on();
        send_head(1'b1, 2'b01, 7'd7);
        for (int i = 0; i < 5; i++) tick(1'b1);
        sel_off();
        repeat (BUSY_CYC / 4) @(negedge clk);
        chk(busy_events == ev0 && ready, "R11", "abort no busy", busy_events - ev0, 0);
        do_read(1'b1, 7'd7, "R11");

        // R10: clear-latch command while busy is ignored
        do_write(1'b1, 1'b1, 7'd9, 16'h0F0F, 1'b0, "R10");
        chk(!ready, "R10", "busy after write", ready, 0);
        do_ext(1'b1, 2'b00, 16'h0, 1'b0);
        wait_idle();
        repeat (2) @(negedge clk);
        do_write(1'b1, 1'b0, 7'd9, 16'hBEEF, 1'b1, "R10");
        do_read(1'b1, 7'd9, "R10");

        // R8 erase-all
        ev0 = busy_events;
        do_ext(1'b1, 2'b10, 16'h0, 1'b1);
        for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
        chk(busy_events == ev0 + 1 && last_len == BUSY_CYC, "R7", "erase busy", last_len, BUSY_CYC);
        do_read(1'b1, 7'd0, "R8");
        do_read(1'b0, 7'd127, "R8");

        // R9 write-all in byte mode
        do_ext(1'b0, 2'b01, 16'h003C, 1'b1);
        for (int i = 0; i < NB; i++) mdl[i] = 8'h3C;
        do_read(1'b1, 7'd63, "R9");
        do_read(1'b0, 7'd64, "R9");

        // R5 clear latch, writes then ignored
        do_ext(1'b0, 2'b00, 16'h0, 1'b0);
        mdl_en = 1'b0;
        do_write(1'b1, 1'b1, 7'd2, 16'h5555, 1'b1, "R4");
        do_read(1'b1, 7'd2, "R5");

        // random phase
        for (int k = 0; k < 40; k++) begin
            logic wide = 1'($urandom);
            logic [6:0] a = 7'($urandom);
            logic [15:0] d = 16'($urandom);
            int pick = $urandom % 8;
            if (pick < 3) begin
                do_write(wide, 1'($urandom), a, d, 1'b1, "R7");
            end else if (pick < 6) begin
                do_read(wide, a, "R6");
            end else if (pick == 6) begin
                do_ext(wide, 2'b11, 16'h0, 1'b0);
                mdl_en = 1'b1;
            end else begin
                do_ext(wide, 2'b00, 16'h0, 1'b0);
                mdl_en = 1'b0;
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule